// File: doc/BRIEF.md
# Word-by-Halfword Signed Multiply-Accumulate

This datapath unit serves the signal-processing extension of a 32-bit processor core. It multiplies a signed 32-bit word by a signed 16-bit halfword picked from one half of a second 32-bit operand. It keeps the upper 32 bits of the 48-bit product and adds a signed 32-bit accumulate value to them. The wrapped 32-bit sum goes to a registered result output.

A signed overflow in that addition sets a sticky saturation flag. The unit does not clamp the result. The flag stays set until reset or until the surrounding core pulses a clear input. The four condition-code bits supplied with the operation go through to the output unaltered.

A valid input qualifies each operation. A parameter chooses between two equivalent circuits for detecting the overflow: an operand-sign comparison or a widened-sum comparison.

Top module: `wxh_mac`

## Requirements
- R1: `hi_sel_i`=0 selects `pair_i[15:0]` as the signed halfword and `hi_sel_i`=1 selects `pair_i[31:16]`. The other half has no effect on any output.
- R2: Both factors are sign-extended to 48 bits and multiplied. Only product bits [47:16] are kept, and the low 16 bits are dropped with no rounding, which truncates toward minus infinity.
- R3: The kept value plus `acc_i`, taken modulo 2^32, appears on `result_o` one clock edge after a cycle with `valid_i`=1. It is never saturated.
- R4: When the signed 32-bit addition overflows on a valid cycle, `q_o` is 1 from the next edge onward.
- R5: Once `q_o` is 1 it stays 1 until reset or a clear, whatever operations follow.
- R6: `clr_q_i`=1 drives `q_o` to 0 at the next edge. If an overflowing valid operation falls in the same cycle, the set wins and `q_o` is 1.
- R7: On a valid cycle `flags_o` takes `flags_i` bit for bit at the next edge. The unit never alters these bits.
- R8: While `valid_i`=0, `result_o` and `flags_o` hold their values and `q_o` is not set, whatever the operands.
- R9: Synchronous active-high `rst` drives `result_o`, `flags_o` and `q_o` to 0.
- R10: The extreme operands are handled exactly: word 0x80000000 times halfword 0x8000 gives kept value 0x40000000. With accumulate 0x7FFFFFFF this gives wrapped result 0xBFFFFFFF and sets the flag. With accumulate 0x80000000 it gives 0xC0000000 and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation qualifier |
| word_i | input | 32 | Signed word factor |
| pair_i | input | 32 | Register holding two halfwords |
| hi_sel_i | input | 1 | 1 selects upper halfword, 0 lower |
| acc_i | input | 32 | Signed accumulate operand |
| flags_i | input | 4 | Condition-code bits to pass through |
| clr_q_i | input | 1 | Clears the sticky flag |
| result_o | output | 32 | Registered wrapped sum |
| flags_o | output | 4 | Registered condition-code bits |
| q_o | output | 1 | Sticky overflow flag |

## Verification
The operation is a single registered stage. `result_o`, `flags_o` and any change to `q_o` caused by a valid cycle or a clear are therefore due at the first rising edge after the inputs are applied. The bench applies operands at a falling edge and samples all three outputs at the next falling edge, after exactly one rising edge. It then drops `valid_i` and `clr_q_i` before the next rising edge, so no operation repeats unseen. In the idle cycles that follow, the bench checks that the held values survive.

// File: rtl/wxh_pkg.sv
`timescale 1ns/1ps
package wxh_pkg;
   // Overflow detection circuit variants
   typedef enum logic {
      OVF_SIGN = 1'b0,   // compare operand and sum signs
      OVF_WIDE = 1'b1    // compare widened sum against narrow sum
   } ovf_mode_e;

   localparam int unsigned CC_W_DEF = 4;
endpackage

// File: rtl/wxh_half_sel.sv
`timescale 1ns/1ps
module wxh_half_sel #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned HALF_W = 16
) (
   input  logic [WORD_W-1:0] pair_i,
   input  logic              hi_sel_i,
   output logic [HALF_W-1:0] half_o
);
   if (WORD_W != 2 * HALF_W) begin : g_bad_split
      $error("wxh_half_sel: WORD_W must be twice HALF_W");
   end

   logic [HALF_W-1:0] lo_half, hi_half;

   assign lo_half = pair_i[HALF_W-1:0];
   assign hi_half = pair_i[WORD_W-1:HALF_W];

   always_comb begin
      half_o = hi_sel_i ? hi_half : lo_half;
   end
endmodule

// File: rtl/wxh_mul.sv
`timescale 1ns/1ps
module wxh_mul #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned HALF_W = 16,
   localparam int unsigned PROD_W = WORD_W + HALF_W
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [HALF_W-1:0] half_i,
   output logic [PROD_W-1:0] prod_o
);
   if (HALF_W < 2 || WORD_W < HALF_W) begin : g_bad_width
      $error("wxh_mul: unsupported factor widths");
   end

   logic signed [PROD_W-1:0] word_ext;
   logic signed [PROD_W-1:0] half_ext;

   // Both factors widened to the full product width; the product of the
   // two most negative values still fits, so truncation loses nothing.
   assign word_ext = {{HALF_W{word_i[WORD_W-1]}}, word_i};
   assign half_ext = {{WORD_W{half_i[HALF_W-1]}}, half_i};
   assign prod_o   = word_ext * half_ext;
endmodule

// File: rtl/wxh_acc_add.sv
`timescale 1ns/1ps
module wxh_acc_add
   import wxh_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned HALF_W   = 16,
   parameter ovf_mode_e   OVF_MODE = OVF_SIGN,
   localparam int unsigned PROD_W  = WORD_W + HALF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PROD_W-1:0] prod_i,
   input  logic [WORD_W-1:0] acc_i,
   output logic [WORD_W-1:0] sum_o,
   output logic              ovf_o
);
   // Variant A: keep upper product bits, add at word width, check signs
   logic [WORD_W-1:0] kept;
   logic [HALF_W-1:0] frac_unused;
   logic [WORD_W-1:0] sum_narrow;
   logic              ovf_sign;

   assign {kept, frac_unused} = prod_i;
   assign sum_narrow = kept + acc_i;
   assign ovf_sign   = (kept[WORD_W-1] == acc_i[WORD_W-1]) &&
                       (sum_narrow[WORD_W-1] != kept[WORD_W-1]);

   // Variant B: add accumulate shifted up by HALF_W at one bit beyond the
   // product width; overflow when the top two bits of the sum disagree
   logic [PROD_W:0]   wsum;
   logic [WORD_W-1:0] sum_wide;
   logic [HALF_W-1:0] wlo_unused;
   logic              ovf_wide;

   assign wsum = {prod_i[PROD_W-1], prod_i} +
                 {acc_i[WORD_W-1], acc_i, {HALF_W{1'b0}}};
   assign {sum_wide, wlo_unused} = wsum[PROD_W-1:0];
   assign ovf_wide = wsum[PROD_W] != wsum[PROD_W-1];

   if (OVF_MODE == OVF_WIDE) begin : g_wide
      assign sum_o = sum_wide;
      assign ovf_o = ovf_wide;
   end else begin : g_sign
      assign sum_o = sum_narrow;
      assign ovf_o = ovf_sign;
   end

   // R4: the two independent overflow circuits must agree
   a_r4_ovf_methods_agree: assert property (@(posedge clk) disable iff (rst)
      ovf_sign == ovf_wide);
   // R3: the two independent sum paths must agree
   a_r3_sum_paths_agree: assert property (@(posedge clk) disable iff (rst)
      sum_narrow == sum_wide);
endmodule

// File: rtl/wxh_sticky.sv
`timescale 1ns/1ps
module wxh_sticky (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (rst)        q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      (q_o && !clr_i) |=> q_o);
   a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      set_i |=> q_o);
   a_r6_clear_alone: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/wxh_mac.sv
`timescale 1ns/1ps
module wxh_mac
   import wxh_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned HALF_W   = 16,
   parameter int unsigned CC_W     = CC_W_DEF,
   parameter ovf_mode_e   OVF_MODE = OVF_SIGN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] pair_i,
   input  logic              hi_sel_i,
   input  logic [WORD_W-1:0] acc_i,
   input  logic [CC_W-1:0]   flags_i,
   input  logic              clr_q_i,
   output logic [WORD_W-1:0] result_o,
   output logic [CC_W-1:0]   flags_o,
   output logic              q_o
);
   localparam int unsigned PROD_W = WORD_W + HALF_W;

   if (CC_W < 1) begin : g_bad_cc
      $error("wxh_mac: CC_W must be at least 1");
   end

   logic [HALF_W-1:0] half;
   logic [PROD_W-1:0] prod;
   logic [WORD_W-1:0] sum;
   logic              ovf;
   logic              q_set;

   wxh_half_sel #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_sel (
      .pair_i   (pair_i),
      .hi_sel_i (hi_sel_i),
      .half_o   (half)
   );

   wxh_mul #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_mul (
      .word_i (word_i),
      .half_i (half),
      .prod_o (prod)
   );

   wxh_acc_add #(.WORD_W(WORD_W), .HALF_W(HALF_W), .OVF_MODE(OVF_MODE)) u_add (
      .clk    (clk),
      .rst    (rst),
      .prod_i (prod),
      .acc_i  (acc_i),
      .sum_o  (sum),
      .ovf_o  (ovf)
   );

   assign q_set = valid_i && ovf;

   wxh_sticky u_q (
      .clk   (clk),
      .rst   (rst),
      .set_i (q_set),
      .clr_i (clr_q_i),
      .q_o   (q_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o <= '0;
         flags_o  <= '0;
      end else if (valid_i) begin
         result_o <= sum;
         flags_o  <= flags_i;
      end
   end

   a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(result_o) && $stable(flags_o));
   a_r8_no_set_idle: assert property (@(posedge clk) disable iff (rst)
      (!valid_i && !q_o) |=> !q_o);
   a_r7_flags_through: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> flags_o == $past(flags_i));
   a_r4_ovf_sets_q: assert property (@(posedge clk) disable iff (rst)
      (valid_i && ovf) |=> q_o);
endmodule

// File: tb/wxh_mac_tb.sv
`timescale 1ns/1ps
module wxh_mac_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        valid_i, hi_sel_i, clr_q_i;
   logic [31:0] word_i, pair_i, acc_i;
   logic [3:0]  flags_i;
   logic [31:0] result_o;
   logic [3:0]  flags_o;
   logic        q_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] m_res;
   logic [3:0]  m_flags;
   logic        m_q;

   always #10 clk = ~clk;   // 50 MHz

   wxh_mac u_dut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .word_i(word_i),
      .pair_i(pair_i), .hi_sel_i(hi_sel_i), .acc_i(acc_i),
      .flags_i(flags_i), .clr_q_i(clr_q_i), .result_o(result_o),
      .flags_o(flags_o), .q_o(q_o)
   );

   // Reference: returns {overflow, wrapped sum}
   function automatic logic [32:0] ref_mac(input logic [31:0] w, input logic [31:0] p,
                                            input logic s, input logic [31:0] a);
      longint wv, hv, pr, kp, sm;
      wv = longint'($signed(w));
      hv = s ? longint'($signed(p[31:16])) : longint'($signed(p[15:0]));
      pr = wv * hv;
      kp = pr >>> 16;
      sm = kp + longint'($signed(a));
      ref_mac = {(sm > 64'sd2147483647) || (sm < -64'sd2147483648), sm[31:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " result"}, result_o, m_res);
      chk({req, " flags"}, {28'd0, flags_o}, {28'd0, m_flags});
      chk({req, " q"}, {31'd0, q_o}, {31'd0, m_q});
   endtask

   // Apply one cycle of stimulus, check one edge later, then go idle
   task automatic op(input string req, input logic v, input logic [31:0] w,
                     input logic [31:0] p, input logic s, input logic [31:0] a,
                     input logic [3:0] f, input logic c);
      logic [32:0] r;
      @(negedge clk);
      valid_i = v; word_i = w; pair_i = p; hi_sel_i = s; acc_i = a;
      flags_i = f; clr_q_i = c;
      r = ref_mac(w, p, s, a);
      @(negedge clk);
      if (v) begin
         m_res = r[31:0];
         m_flags = f;
      end
      if (v && r[32]) m_q = 1'b1;
      else if (c)     m_q = 1'b0;
      check_all(req);
      valid_i = 1'b0;
      clr_q_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst = 1'b1; valid_i = 1'b0; hi_sel_i = 1'b0; clr_q_i = 1'b0;
      word_i = '1; pair_i = '1; acc_i = '1; flags_i = 4'hF;
      m_res = '0; m_flags = '0; m_q = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_all("R9 reset");

      // R1: low and high half selection, junk in the unused half
      op("R1 low half", 1, 32'd1000, 32'hDEAD_0007, 1'b0, 32'd0, 4'h1, 0);
      chk("R1 low value", result_o, 32'd0);   // 7000>>16 = 0
      op("R1 low half big", 1, 32'h0001_0000, 32'hDEAD_0007, 1'b0, 32'd5, 4'h2, 0);
      chk("R1 low direct", result_o, 32'd12);
      op("R1 high half", 1, 32'h0001_0000, 32'hFFFD_1234, 1'b1, 32'd0, 4'h3, 0);
      chk("R1 high direct", result_o, 32'hFFFF_FFFD);
      // R2: truncation toward minus infinity
      op("R2 trunc pos", 1, 32'd1, 32'h0000_0001, 1'b0, 32'd0, 4'h4, 0);
      chk("R2 pos direct", result_o, 32'd0);
      op("R2 trunc neg", 1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'd0, 4'h5, 0);
      chk("R2 neg direct", result_o, 32'hFFFF_FFFF);
      // R10 / R3 / R4: extreme product with extreme accumulates
      op("R10 ext min acc", 1, 32'h8000_0000, 32'h0000_8000, 1'b0, 32'h8000_0000, 4'h6, 0);
      chk("R10 min acc direct", result_o, 32'hC000_0000);
      chk("R10 no q", {31'd0, q_o}, 32'd0);
      op("R10 ext max acc", 1, 32'h8000_0000, 32'h8000_1111, 1'b1, 32'h7FFF_FFFF, 4'h7, 0);
      chk("R3 wrapped direct", result_o, 32'hBFFF_FFFF);
      chk("R4 q set", {31'd0, q_o}, 32'd1);
      // R5: sticky through a clean op
      op("R5 sticky", 1, 32'd3, 32'd4, 1'b0, 32'd9, 4'h8, 0);
      chk("R5 q held", {31'd0, q_o}, 32'd1);
      // R6: clear alone
      op("R6 clear", 0, 32'd0, 32'd0, 1'b0, 32'd0, 4'h0, 1);
      chk("R6 q cleared", {31'd0, q_o}, 32'd0);
      // R8: invalid overflowing operands change nothing
      op("R8 idle", 0, 32'h8000_0000, 32'h0000_8000, 1'b0, 32'h7FFF_FFFF, 4'hA, 0);
      chk("R8 q not set", {31'd0, q_o}, 32'd0);
      // R6: clear and negative overflow together, set wins
      op("R6 set wins", 1, 32'h7FFF_FFFF, 32'h0000_8000, 1'b0, 32'h8000_0000, 4'hB, 1);
      chk("R6 set direct", result_o, 32'h4000_0000);
      chk("R6 q wins", {31'd0, q_o}, 32'd1);
      op("R6 clear again", 0, 32'd0, 32'd0, 1'b0, 32'd0, 4'h0, 1);

      // R3 R7 R8: random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w, p, a;
         w = $urandom(); p = $urandom(); a = $urandom();
         if (($urandom() % 8) == 0) w = ($urandom() % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
         if (($urandom() % 8) == 0) a = ($urandom() % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
         op("R3 R7 random", ($urandom() % 4) != 0, w, p, 1'($urandom()), a,
            4'($urandom()), ($urandom() % 6) == 0);
      end

      // R9: reset mid-run
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      m_res = '0; m_flags = '0; m_q = 1'b0;
      check_all("R9 reset again");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule